// File: doc/BRIEF.md
# Dead-Band-Free Phase-Frequency Detector

This block compares a reference clock with a divided oscillator clock and produces one digital level for an external loop filter. Each input is first brought into the system clock domain, and each of its rising edges toggles a divide-by-two flop. This gives two square waves at half the input rate with exact 50% duty cycle. Near lock the output is the XOR of these two halved waves. Its average value therefore varies linearly with phase difference, right through zero, with no dead zone. The loop settles where the halved waves sit a quarter period apart.

Two steering flops deal with large frequency errors. If one input shows two rising edges with no edge on the other input in between, the steering flops override the XOR. The output is held high when the reference is ahead (the oscillator runs slow) and held low when the oscillator is ahead. One edge of the trailing input releases the override. Both inputs and the clock are sampled synchronously. The depth of the input synchronizer and an optional output register are parameters.

Top module: `dbf_pfd`

## Requirements
- R1: While rst_n is low, all divide, steering, synchronizer and output flops are cleared, and pd_out is 0.
- R2: Each rising edge of an input, as seen after synchronization, inverts that input's halved square wave. Between edges the halved wave holds its value.
- R3: When no override is active, pd_out is the XOR of the two halved waves. Two equal-rate inputs offset by half of their input period give a 50% duty output.
- R4: When the reference shows a second rising edge with no oscillator edge since its previous one, pd_out is held at 1 (the oscillator lags).
- R5: When the oscillator shows a second rising edge with no reference edge since its previous one, pd_out is held at 0 (the oscillator leads).
- R6: An active override persists through further edges of the leading input. It is cleared by a single edge of the other input, and that edge also toggles its halved wave.
- R7: Rising edges on both inputs in the same clock cycle toggle both halved waves and leave the override state and edge order unchanged.
- R8: A rising edge applied before clock edge k affects pd_out just after clock edge k + SYNC_STAGES + OUT_REG.
- R9: The high and low overrides are never active together.
- R10: For equal-rate inputs with input period P cycles and offset d cycles (0 ≤ d < P/2), pd_out is high for 2d out of every 2P cycles. A one-cycle offset therefore gives a nonzero output (no dead band).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference clock input (sampled) |
| vco_in | input | 1 | Divided oscillator input (sampled) |
| pd_out | output | 1 | Phase/frequency error level to the loop filter |

## Verification
The bench targets edge ordering: two consecutive edges on one input, the single releasing edge of the other input, and coincident edges while an override is held. A design that miscounted order would stick in an override, release it early, or flip the wrong direction. The bench also measures duty at one-cycle and quarter-period offsets. A detector with a dead band would report zero at the small offset, and an off-by-one pipeline would fail the per-cycle latency comparison.

// File: rtl/dbf_pfd_pkg.sv
package dbf_pfd_pkg;

   // Which input produced the most recent lone rising edge
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_REF  = 2'd1,
      SRC_VCO  = 2'd2
   } src_e;

   localparam int unsigned MAX_SYNC_STAGES = 4;

endpackage

// File: rtl/dbf_pfd_edge.sv
module dbf_pfd_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_in,
   output logic edge_o
);
   logic sampled;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sampled = sig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= sig_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign sampled = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sampled;
   end

   assign edge_o = sampled & ~prev_q;
endmodule

// File: rtl/dbf_pfd_halver.sv
module dbf_pfd_halver (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_i,
   output logic div_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_o <= 1'b0;
      else if (edge_i) div_o <= ~div_o;
   end
endmodule

// File: rtl/dbf_pfd_steer.sv
module dbf_pfd_steer
   import dbf_pfd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ref_edge,
   input  logic vco_edge,
   output logic force_hi,
   output logic force_lo
);
   src_e last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_hi <= 1'b0;
         force_lo <= 1'b0;
         last_q   <= SRC_NONE;
      end else begin
         unique case ({ref_edge, vco_edge})
            2'b10: begin
               if (force_lo)              force_lo <= 1'b0;
               else if (last_q == SRC_REF) force_hi <= 1'b1;
               last_q <= SRC_REF;
            end
            2'b01: begin
               if (force_hi)              force_hi <= 1'b0;
               else if (last_q == SRC_VCO) force_lo <= 1'b1;
               last_q <= SRC_VCO;
            end
            default: begin
               // no edge, or coincident edges: order unchanged
            end
         endcase
      end
   end
endmodule

// File: rtl/dbf_pfd.sv
module dbf_pfd
   import dbf_pfd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned OUT_REG     = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_in,
   input  logic vco_in,
   output logic pd_out
);
   generate
      if (SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
         $error("dbf_pfd: SYNC_STAGES exceeds supported depth");
      end
      if (OUT_REG > 1) begin : g_bad_oreg
         $error("dbf_pfd: OUT_REG must be 0 or 1");
      end
   endgenerate

   logic ref_edge, vco_edge;
   logic ref_div, vco_div;
   logic force_hi, force_lo;
   logic phase_lvl;

   dbf_pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
      .clk(clk), .rst_n(rst_n), .sig_in(ref_in), .edge_o(ref_edge)
   );
   dbf_pfd_edge #(.SYNC_STAGES(SYNC_STAGES)) u_vco_edge (
      .clk(clk), .rst_n(rst_n), .sig_in(vco_in), .edge_o(vco_edge)
   );

   dbf_pfd_halver u_ref_half (
      .clk(clk), .rst_n(rst_n), .edge_i(ref_edge), .div_o(ref_div)
   );
   dbf_pfd_halver u_vco_half (
      .clk(clk), .rst_n(rst_n), .edge_i(vco_edge), .div_o(vco_div)
   );

   dbf_pfd_steer u_steer (
      .clk(clk), .rst_n(rst_n),
      .ref_edge(ref_edge), .vco_edge(vco_edge),
      .force_hi(force_hi), .force_lo(force_lo)
   );

   // Override wins over the XOR comparison
   always_comb begin
      if (force_hi)      phase_lvl = 1'b1;
      else if (force_lo) phase_lvl = 1'b0;
      else               phase_lvl = ref_div ^ vco_div;
   end

   generate
      if (OUT_REG != 0) begin : g_oreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pd_out <= 1'b0;
            else        pd_out <= phase_lvl;
         end
      end else begin : g_ocomb
         assign pd_out = phase_lvl;
      end
   endgenerate
endmodule

// File: rtl/dbf_pfd_chk.sv
module dbf_pfd_chk #(
   parameter int unsigned OUT_REG = 1
) (
   input logic clk,
   input logic rst_n,
   input logic ref_edge,
   input logic vco_edge,
   input logic ref_div,
   input logic vco_div,
   input logic force_hi,
   input logic force_lo,
   input logic pd_out
);
   // R1: output cleared while reset is held
   a_r1_reset_out: assert property (@(posedge clk) !rst_n |-> !pd_out);

   // R2: halved wave inverts on its edge and only then
   a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      ref_edge |=> ref_div != $past(ref_div));
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !vco_edge |=> $stable(vco_div));

   // R6: override survives leading-input edges, released by the other input
   a_r6_hi_persist: assert property (@(posedge clk) disable iff (!rst_n)
      force_hi && !vco_edge |=> force_hi);
   a_r6_hi_release: assert property (@(posedge clk) disable iff (!rst_n)
      force_hi && vco_edge && !ref_edge |=> !force_hi && !force_lo);
   a_r6_lo_release: assert property (@(posedge clk) disable iff (!rst_n)
      force_lo && ref_edge && !vco_edge |=> !force_lo && !force_hi);

   // R7: coincident edges leave steering untouched
   a_r7_coincident: assert property (@(posedge clk) disable iff (!rst_n)
      ref_edge && vco_edge |=> force_hi == $past(force_hi) && force_lo == $past(force_lo));

   // R9: overrides mutually exclusive
   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({force_hi, force_lo}));

   // R4 / R5: override reaches the output
   generate
      if (OUT_REG != 0) begin : g_reg_chk
         a_r4_hi_out: assert property (@(posedge clk) disable iff (!rst_n)
            force_hi |=> pd_out);
         a_r5_lo_out: assert property (@(posedge clk) disable iff (!rst_n)
            force_lo |=> !pd_out);
      end else begin : g_comb_chk
         a_r4_hi_out: assert property (@(posedge clk) disable iff (!rst_n)
            force_hi |-> pd_out);
         a_r5_lo_out: assert property (@(posedge clk) disable iff (!rst_n)
            force_lo |-> !pd_out);
      end
   endgenerate
endmodule

bind dbf_pfd dbf_pfd_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .ref_edge(ref_edge), .vco_edge(vco_edge),
   .ref_div(ref_div), .vco_div(vco_div),
   .force_hi(force_hi), .force_lo(force_lo),
   .pd_out(pd_out)
);

// File: tb/dbf_pfd_bench.sv
module dbf_pfd_bench;
   localparam int unsigned SYNC_STAGES = 2;
   localparam int unsigned OUT_REG     = 1;
   localparam int          LAG         = SYNC_STAGES + OUT_REG;

   logic clk = 1'b0;
   logic rst_n;
   logic ref_in, vco_in;
   logic pd_out;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   dbf_pfd #(.SYNC_STAGES(SYNC_STAGES), .OUT_REG(OUT_REG)) u_dbf_pfd (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in), .pd_out(pd_out)
   );

   // ---------------- reference model (from the requirements) -------------
   bit m_rd, m_vd, m_pr, m_pv;
   int m_mode;   // 0 compare, 1 held high, 2 held low
   int m_last;   // 0 none, 1 ref, 2 vco
   bit exp_h [16];
   int mode_h[16];
   int cyc;
   int hi_count;
   string tag;

   function automatic bit model_out();
      if (m_mode == 1) return 1'b1;
      if (m_mode == 2) return 1'b0;
      return m_rd ^ m_vd;
   endfunction

   task automatic model_reset();
      m_rd = 0; m_vd = 0; m_pr = 0; m_pv = 0; m_mode = 0; m_last = 0;
      for (int i = 0; i < 16; i++) begin exp_h[i] = 0; mode_h[i] = 0; end
      cyc = 0;
   endtask

   task automatic model_step(input bit r, input bit v);
      bit er, ev;
      er = r & ~m_pr;
      ev = v & ~m_pv;
      m_pr = r; m_pv = v;
      if (er && ev) begin
         m_rd = ~m_rd; m_vd = ~m_vd;
      end else if (er) begin
         m_rd = ~m_rd;
         if (m_mode == 2) m_mode = 0;
         else if (m_last == 1) m_mode = 1;
         m_last = 1;
      end else if (ev) begin
         m_vd = ~m_vd;
         if (m_mode == 1) m_mode = 0;
         else if (m_last == 2) m_mode = 2;
         m_last = 2;
      end
   endtask

   task automatic check(input bit ok, input string req, input bit act, input bit exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual %0b expected %0b", req, cyc, act, exp);
      end
   endtask

   // one clock: sample output (R8 timing), then drive next inputs
   task automatic step(input bit r, input bit v);
      bit e; int md; string req;
      @(negedge clk);
      if (cyc - 1 - LAG >= 0) begin
         e  = exp_h[(cyc - 1 - LAG) % 16];
         md = mode_h[(cyc - 1 - LAG) % 16];
      end else begin
         e = 0; md = 0;
      end
      req = (md == 1) ? "R4" : (md == 2) ? "R5" : "R3";
      check(pd_out === e, {req, " R8 ", tag}, pd_out, e);
      if (pd_out === 1'b1) hi_count++;
      ref_in = r; vco_in = v;
      model_step(r, v);
      exp_h[cyc % 16]  = model_out();
      mode_h[cyc % 16] = m_mode;
      cyc++;
   endtask

   task automatic pulse(input bit r, input bit v);
      step(r, v); step(0, 0); step(0, 0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; ref_in = 0; vco_in = 0;
      repeat (2) @(negedge clk);
      check(pd_out === 1'b0, "R1 reset", pd_out, 1'b0);
      model_reset();
      rst_n = 1;
   endtask

   task automatic waves(input int pr, input int pv, input int off, input int n);
      for (int i = 0; i < n; i++) begin
         bit r, v;
         r = (i % pr) < (pr / 2);
         v = (i >= off) ? (((i - off) % pv) < (pv / 2)) : 1'b0;
         step(r, v);
      end
   endtask

   // R10 / R3: duty over a steady window, input period 8
   task automatic duty_check(input int off, input int want, input string req);
      do_reset();
      tag = req;
      waves(8, 8, off, 64);
      hi_count = 0;
      for (int i = 64; i < 128; i++) begin
         bit r, v;
         r = (i % 8) < 4;
         v = ((i - off) % 8) < 4;
         step(r, v);
      end
      checks++;
      if (hi_count != want) begin
         errors++;
         $display("FAIL %s duty offset %0d: actual %0d expected %0d", req, off, hi_count, want);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0a1d));
      rst_n = 0; ref_in = 0; vco_in = 0;
      model_reset();
      tag = "R1";
      repeat (3) @(negedge clk);
      check(pd_out === 1'b0, "R1 initial reset", pd_out, 1'b0);
      rst_n = 1;

      // R8 latency and R2 halving: alternate lone edges
      tag = "R2 R8";
      idle(4);
      for (int i = 0; i < 4; i++) begin pulse(1, 0); idle(3); pulse(0, 1); idle(3); end

      // R4 then R6: two reference edges hold high, extra ref edge keeps it, one vco edge frees
      tag = "R4 R6";
      pulse(1, 0); pulse(1, 0); idle(4); pulse(1, 0); idle(4); pulse(0, 1); idle(6);

      // R5 then R6
      tag = "R5 R6";
      pulse(0, 1); pulse(0, 1); idle(4); pulse(0, 1); idle(4); pulse(1, 0); idle(6);

      // R7: coincident edges while held high, then release
      tag = "R7";
      pulse(1, 0); pulse(1, 0); pulse(1, 1); idle(4); pulse(1, 1); idle(4);
      pulse(0, 1); idle(4); pulse(1, 1); idle(6);

      // R1: reset in the middle of an override
      tag = "R1 R4";
      pulse(1, 0); pulse(1, 0); idle(4);
      do_reset();
      tag = "R1";
      idle(6);

      // R10: linear, no dead band; R3: quadrature gives 50%
      duty_check(1, 8,  "R10");
      duty_check(2, 16, "R10");
      duty_check(4, 32, "R3 R10");

      // constrained random: rate pairs and offsets
      do_reset();
      tag = "R9 random waves";
      for (int s = 0; s < 12; s++) begin
         int pr, pv, off;
         pr  = 4 + ($urandom % 9);
         pv  = 4 + ($urandom % 9);
         off = $urandom % 8;
         waves(pr, pv, off, 300);
      end
      tag = "R9 random bits";
      for (int i = 0; i < 2000; i++) step($urandom % 2, $urandom % 2);
      idle(LAG + 2);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule